// File: doc/BRIEF.md
# Split-Space Memory Select Decoder

This block turns one bus access into chip selects for a read-only device and a read/write device that hang on the same address and data wires. Every access carries a 16-bit address, a space bit (0 = program/constant space, 1 = variable space) and a read or write strobe. In program space, the lower half of the range belongs to the read-only device. The upper half is redirected to the read/write device at the identical address, so code copied into variable space at 0x8000 and above can be fetched from program space at the same address. The lower halves of the two spaces remain separate devices. The processor boots from program address 0x0000, and loaded applications start at 0x8000.

Writes that would land in the read-only half are dropped. No device is selected and no write enable is driven, and an error pulse is raised instead. For every access that reaches the read/write device, the block also reports which region of variable memory the address falls in. The regions are system variables, stack, application data and application code.

No data passes through the block, so it has no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal. By default the outputs are registered, which gives a fixed latency of one cycle. A parameter selects purely combinational outputs instead.

Top module: `memsel_decode`

## Requirements
- R1: A read in program space (space bit 0) with address bit 15 = 0 asserts `rom_ce` and `mem_oe`, and leaves `ram_ce` low.
- R2: A read in program space with address bit 15 = 1 asserts `ram_ce` and `mem_oe`, and leaves `rom_ce` low. The address is not altered, so the access is the same location as the equal variable-space address.
- R3: A read in variable space (space bit 1) at any address asserts `ram_ce` and `mem_oe`.
- R4: A write in program space with address bit 15 = 0 drives `rom_ce`, `ram_ce`, `mem_we` and `mem_oe` low. It raises `rom_wr_err` for exactly one output cycle per such write cycle.
- R5: A write to the read/write device (variable space, or program space with bit 15 = 1) asserts `ram_ce` and `mem_we`, and leaves `mem_oe` and `rom_ce` low.
- R6: With neither strobe active, all enables, `region_vld` and `rom_wr_err` are low, and `region` is 0.
- R7: When `ram_ce` is high, `region_vld` is high and `region` encodes the address as follows: 0 below 0x0F00, 1 for 0x0F00–0x0FFF, 2 for 0x1000–0x7FFF and 3 for 0x8000–0xFFFF. Otherwise `region_vld` is low and `region` is 0.
- R8: `rom_ce` and `ram_ce` are never high together.
- R9: With REG_OUT = 1 (default), all outputs are low while `rst_n` is low. Otherwise each output reflects the inputs sampled at the previous rising clock edge.
- R10: If both strobes are active in the same cycle, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used when REG_OUT = 1) |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| acc_addr | input | 16 | Access address on the shared bus |
| acc_space | input | 1 | 0 = program/constant space, 1 = variable space |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| rom_ce | output | 1 | Read-only device chip enable |
| ram_ce | output | 1 | Read/write device chip enable |
| mem_oe | output | 1 | Output enable for the selected device |
| mem_we | output | 1 | Write enable for the read/write device |
| region | output | 2 | Variable-memory region code |
| region_vld | output | 1 | Region code is meaningful |
| rom_wr_err | output | 1 | Pulse: a write to the read-only half was dropped |

## Verification
In the default build, every output is due exactly one rising edge after the address, space and strobes that produced it are applied. The enables, the region code and the error pulse all share this latency. The bench drives a new access on each falling edge. On the next falling edge it compares the outputs against a model result that was computed when that access was driven and held for one cycle. Because each comparison happens half a period away from the clock edge, it always sees the settled response to exactly one earlier access.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

  typedef enum logic [1:0] {
    RGN_SYSVAR  = 2'd0,
    RGN_STACK   = 2'd1,
    RGN_APPDATA = 2'd2,
    RGN_APPCODE = 2'd3
  } rgn_e;

  localparam logic SPACE_PROG = 1'b0;
  localparam logic SPACE_VAR  = 1'b1;

  typedef struct packed {
    logic rom_ce;
    logic ram_ce;
    logic oe;
    logic we;
    logic wr_err;
    logic rgn_vld;
    rgn_e rgn;
  } sel_t;

  localparam int SEL_W = $bits(sel_t);

endpackage

// File: rtl/memsel_space_dec.sv
module memsel_space_dec
  import memsel_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              space,
  input  logic              rd,
  input  logic              wr,
  output logic              rom_ce,
  output logic              ram_ce,
  output logic              oe,
  output logic              we,
  output logic              wr_err
);
  localparam int HALF_BIT = ADDR_W - 1;

  logic upper_half;
  logic to_rom;
  logic is_write;
  logic is_read;

  assign upper_half = addr[HALF_BIT];
  assign to_rom     = (space == SPACE_PROG) && !upper_half;
  assign is_write   = wr;
  assign is_read    = rd && !wr;

  always_comb begin
    rom_ce = 1'b0;
    ram_ce = 1'b0;
    oe     = 1'b0;
    we     = 1'b0;
    wr_err = 1'b0;
    if (is_write) begin
      if (to_rom) begin
        wr_err = 1'b1;
      end else begin
        ram_ce = 1'b1;
        we     = 1'b1;
      end
    end else if (is_read) begin
      oe = 1'b1;
      if (to_rom) rom_ce = 1'b1;
      else        ram_ce = 1'b1;
    end
  end

endmodule

// File: rtl/memsel_region_dec.sv
module memsel_region_dec
  import memsel_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] STACK_BASE = 16'h0F00,
  parameter logic [ADDR_W-1:0] APP_BASE   = 16'h1000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              hit,
  output logic              rgn_vld,
  output rgn_e              rgn
);
  localparam int HALF_BIT = ADDR_W - 1;

  always_comb begin
    rgn_vld = hit;
    rgn     = RGN_SYSVAR;
    if (hit) begin
      if (addr[HALF_BIT])         rgn = RGN_APPCODE;
      else if (addr >= APP_BASE)  rgn = RGN_APPDATA;
      else if (addr >= STACK_BASE) rgn = RGN_STACK;
      else                        rgn = RGN_SYSVAR;
    end
  end

endmodule

// File: rtl/memsel_out_stage.sv
module memsel_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (REG_OUT) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d;
      end
      assign q = q_r;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/memsel_decode.sv
module memsel_decode
  import memsel_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] STACK_BASE = 16'h0F00,
  parameter logic [ADDR_W-1:0] APP_BASE   = 16'h1000,
  parameter bit                REG_OUT    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_space,
  input  logic              acc_rd,
  input  logic              acc_wr,
  output logic              rom_ce,
  output logic              ram_ce,
  output logic              mem_oe,
  output logic              mem_we,
  output logic [1:0]        region,
  output logic              region_vld,
  output logic              rom_wr_err
);
  sel_t sel_d;
  sel_t sel_q;
  logic [SEL_W-1:0] sel_q_v;

  memsel_space_dec #(.ADDR_W(ADDR_W)) u_space (
    .addr   (acc_addr),
    .space  (acc_space),
    .rd     (acc_rd),
    .wr     (acc_wr),
    .rom_ce (sel_d.rom_ce),
    .ram_ce (sel_d.ram_ce),
    .oe     (sel_d.oe),
    .we     (sel_d.we),
    .wr_err (sel_d.wr_err)
  );

  memsel_region_dec #(
    .ADDR_W     (ADDR_W),
    .STACK_BASE (STACK_BASE),
    .APP_BASE   (APP_BASE)
  ) u_region (
    .addr    (acc_addr),
    .hit     (sel_d.ram_ce),
    .rgn_vld (sel_d.rgn_vld),
    .rgn     (sel_d.rgn)
  );

  memsel_out_stage #(.W(SEL_W), .REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sel_d),
    .q     (sel_q_v)
  );

  assign sel_q      = sel_t'(sel_q_v);
  assign rom_ce     = sel_q.rom_ce;
  assign ram_ce     = sel_q.ram_ce;
  assign mem_oe     = sel_q.oe;
  assign mem_we     = sel_q.we;
  assign rom_wr_err = sel_q.wr_err;
  assign region_vld = sel_q.rgn_vld;
  assign region     = sel_q.rgn;

endmodule

// File: rtl/memsel_decode_chk.sv
module memsel_decode_chk #(
  parameter int ADDR_W  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_space,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic              rom_ce,
  input logic              ram_ce,
  input logic              mem_oe,
  input logic              mem_we,
  input logic [1:0]        region,
  input logic              region_vld,
  input logic              rom_wr_err
);
  AST_CE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({rom_ce, ram_ce})); // R8
  AST_WE_RAM_ONLY: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> (ram_ce && !mem_oe)); // R5
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) rom_wr_err |-> (!rom_ce && !ram_ce && !mem_we && !mem_oe)); // R4
  AST_RGN_TRACKS_RAM: assert property (@(posedge clk) disable iff (!rst_n) region_vld == ram_ce); // R7
  AST_RGN_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !region_vld |-> (region == 2'd0)); // R7

  generate
    if (REG_OUT) begin : g_seq
      AST_PROG_LOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !acc_wr && !acc_space && !acc_addr[ADDR_W-1]) |=> (rom_ce && mem_oe)); // R1
      AST_MIRROR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !acc_wr && !acc_space && acc_addr[ADDR_W-1]) |=> (ram_ce && region == 2'd3)); // R2
      AST_IDLE_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rd && !acc_wr) |=> (!rom_ce && !ram_ce && !rom_wr_err)); // R6
      AST_BOTH_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && acc_wr) |=> !mem_oe); // R10
    end
  endgenerate

endmodule

bind memsel_decode memsel_decode_chk #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_addr   (acc_addr),
  .acc_space  (acc_space),
  .acc_rd     (acc_rd),
  .acc_wr     (acc_wr),
  .rom_ce     (rom_ce),
  .ram_ce     (ram_ce),
  .mem_oe     (mem_oe),
  .mem_we     (mem_we),
  .region     (region),
  .region_vld (region_vld),
  .rom_wr_err (rom_wr_err)
);

// File: tb/memsel_decode_tb.sv
module memsel_decode_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] acc_addr;
  logic        acc_space;
  logic        acc_rd;
  logic        acc_wr;
  logic        rom_ce, ram_ce, mem_oe, mem_we, region_vld, rom_wr_err;
  logic [1:0]  region;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  memsel_decode u_dut (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_space(acc_space),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .rom_ce(rom_ce), .ram_ce(ram_ce),
    .mem_oe(mem_oe), .mem_we(mem_we), .region(region),
    .region_vld(region_vld), .rom_wr_err(rom_wr_err)
  );

  // expected vector: rom_ce ram_ce oe we err vld region[1:0]
  logic [7:0] exp_q[$];
  string      tag_q[$];

  function automatic logic [7:0] model(input int a, input bit sp, input bit rd, input bit wr);
    bit rc = 0, mc = 0, oe = 0, we = 0, er = 0;
    int rg = 0;
    bit low_prog = (sp == 0) && (a < 32768);
    if (wr) begin
      if (low_prog) er = 1; else begin mc = 1; we = 1; end
    end else if (rd) begin
      oe = 1;
      if (low_prog) rc = 1; else mc = 1;
    end
    if (mc) rg = (a >= 32768) ? 3 : (a >= 4096) ? 2 : (a >= 3840) ? 1 : 0;
    return {rc, mc, oe, we, er, mc, 2'(rg)};
  endfunction

  function automatic string tag_of(input int a, input bit sp, input bit rd, input bit wr);
    if (rd && wr) return "R10";
    if (wr) return (sp == 0 && a < 32768) ? "R4" : "R5";
    if (rd) return (sp == 1) ? "R3" : (a < 32768) ? "R1" : "R2";
    return "R6";
  endfunction

  function automatic logic [7:0] actual();
    return {rom_ce, ram_ce, mem_oe, mem_we, rom_wr_err, region_vld, region};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive at negedge: first compare pending expectation, then apply new access
  task automatic access(input int a, input bit sp, input bit rd, input bit wr);
    @(negedge clk);
    if (exp_q.size() > 0) begin
      logic [7:0] e = exp_q.pop_front();
      string t = tag_q.pop_front();
      logic [7:0] act = actual();
      check(t, act, e);
      check("R7", act[2:0], e[2:0]);
      check("R8", {7'd0, rom_ce & ram_ce}, 8'd0);
    end
    acc_addr  = a[15:0];
    acc_space = sp;
    acc_rd    = rd;
    acc_wr    = wr;
    exp_q.push_back(model(a, sp, rd, wr));
    tag_q.push_back(tag_of(a, sp, rd, wr));
  endtask

  initial begin
    rst_n = 1'b0; acc_addr = 16'h0000; acc_space = 1'b0; acc_rd = 1'b1; acc_wr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", actual(), 8'd0); // outputs held low in reset despite a read strobe
    rst_n = 1'b1; acc_rd = 1'b0;
    // directed: boot fetch, application start, boundaries
    access(16'h0000, 0, 1, 0);   // R1 boot vector
    access(16'h7FFF, 0, 1, 0);   // R1 top of ROM half
    access(16'h8000, 0, 1, 0);   // R2 application start, mirrored
    access(16'hFFFF, 0, 1, 0);   // R2
    access(16'h8000, 1, 1, 0);   // R3 same byte from variable space
    access(16'h0EFF, 1, 1, 0);   // R7 sysvar top
    access(16'h0F00, 1, 1, 0);   // R7 stack base
    access(16'h0FFF, 1, 0, 1);   // R7 stack top, write
    access(16'h1000, 1, 1, 0);   // R7 app data base
    access(16'h7FFF, 1, 0, 1);   // R5
    access(16'h0000, 1, 0, 1);   // R5 sysvar write
    access(16'h0000, 0, 0, 1);   // R4 ROM write dropped
    access(16'h7FFF, 0, 0, 1);   // R4 back to back
    access(16'h1234, 0, 0, 0);   // R6 idle, one-cycle error pulse ends
    access(16'h8001, 0, 0, 1);   // R5 write through mirror
    access(16'h0100, 0, 1, 1);   // R10 both strobes -> dropped write
    access(16'h9000, 1, 1, 1);   // R10 both strobes -> RAM write
    access(16'hFFFF, 1, 0, 0);   // R6
    for (int i = 0; i < 400; i++)
      access(int'($urandom_range(0, 65535)), bit'($urandom_range(0, 1)),
             bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    access(16'h0000, 0, 0, 0);   // flush last pending check
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule